// File: doc/BRIEF.md
# Edge-Weighted Decision Diagram Function Evaluator

This block returns the value of one fixed integer function of two fixed-point operands. The function is held as a multi-valued decision diagram whose edges carry integer weights. The diagram sits in an internal constant edge table. To evaluate the function, the block walks from the root node to the terminal node along the edges that the operand bits select, and adds up the weights of the edges it crosses. The sum at the terminal node is the function value.

Each edge record gives four things for the node the edge leads to: its table address, how far to shift the operand word before that node's bits are read, which window bits belong to that node's variable, and the weight of the edge. A pulse on `start` captures the operands. The walk then reads one edge record per clock. A one-cycle `done` pulse marks the result. The default table encodes the rounded Euclidean norm of two 2-bit operands. It uses one 3-bit group {x1,x0,y1} followed by one 1-bit group {y0}.

Top module: `evdd_eval`

## Requirements
- R1: The operand word is `{op_x, op_y}`, with op_x in the upper half. The first edge address is the top 3 bits of that word (node address 0, full mask, no shift).
- R2: Each later edge address is the edge record's node address plus (the top 3 bits of the operand word, after it has been shifted left by the record's shift amount) AND the record's mask.
- R3: The running sum is cleared when a start is accepted. The signed weight of every edge record read is added to it.
- R4: An edge record whose mask is all zeros leads to the terminal node. Its weight is still added, and the total becomes `result`.
- R5: A walk over L edges raises `done` on the L-th rising edge after the edge that accepts `start`. That is one clock per edge record.
- R6: `done` is high for exactly one clock per walk.
- R7: `start` has no effect while a walk is in progress. The result and the latency are those of the operands captured first.
- R8: `result` changes only on the edge that raises `done`. Between walks it holds its value.
- R9: After reset, `done` is 0 and `result` is 0.
- R10: With the default table, `result` equals the nearest integer to sqrt(X*X+Y*Y) for every X,Y in 0..3. For example, X=2,Y=2 gives 3 after two edges (addresses 5 and 8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an evaluation with the present operands |
| op_x | input | OP_W (2) | First operand, upper half of the operand word |
| op_y | input | OP_W (2) | Second operand, lower half of the operand word |
| done | output | 1 | One-cycle pulse: result is valid |
| result | output | SUM_W (6) | Signed function value, held until the next completion |

## Verification
All sixteen operand pairs are run, and each result is compared with a rounded square root computed in integer arithmetic. The norm is symmetric, so the value alone cannot catch swapped operand halves or a misplaced window. The latency can: pairs whose lower operand bit leaves the value unchanged end after one edge, and the others need a second node. A start that arrives during a walk with different operands separates a block that ignores it from one that restarts. Checks on the clocks after each completion separate a one-cycle `done` pulse and a held result from a level or a drifting value.

// File: rtl/evdd_pkg.sv
package evdd_pkg;
    localparam int OP_W       = 2;
    localparam int IN_W       = 2 * OP_W;
    localparam int WIN_W      = 3;
    localparam int ADDR_W     = 4;
    localparam int SHIFT_W    = 2;
    localparam int WEIGHT_W   = 4;
    localparam int SUM_W      = 6;
    localparam int EDGE_DEPTH = 10;

    typedef struct packed {
        logic [ADDR_W-1:0]          node;
        logic [SHIFT_W-1:0]         shift;
        logic [WIN_W-1:0]           mask;
        logic signed [WEIGHT_W-1:0] weight;
    } edge_rec_t;

    typedef enum logic {ST_IDLE, ST_WALK} walk_state_e;

    function automatic edge_rec_t mk_edge(int node, int sh, int msk, int w);
        edge_rec_t r;
        r.node   = ADDR_W'(node);
        r.shift  = SHIFT_W'(sh);
        r.mask   = WIN_W'(msk);
        r.weight = WEIGHT_W'(w);
        return r;
    endfunction

    // Rounded 2-D norm of two 2-bit operands; root at 0, y0 node at 8.
    function automatic edge_rec_t [EDGE_DEPTH-1:0] norm_table();
        edge_rec_t [EDGE_DEPTH-1:0] t;
        t[0] = mk_edge(8, 1, 1, 0);
        t[1] = mk_edge(8, 1, 1, 2);
        t[2] = mk_edge(0, 0, 0, 1);
        t[3] = mk_edge(8, 1, 1, 2);
        t[4] = mk_edge(0, 0, 0, 2);
        t[5] = mk_edge(8, 1, 1, 3);
        t[6] = mk_edge(0, 0, 0, 3);
        t[7] = mk_edge(0, 0, 0, 4);
        t[8] = mk_edge(0, 0, 0, 0);
        t[9] = mk_edge(0, 0, 0, 1);
        return t;
    endfunction

    localparam edge_rec_t [EDGE_DEPTH-1:0] NORM_TABLE = norm_table();
endpackage

// File: rtl/evdd_edge_rom.sv
module evdd_edge_rom
    import evdd_pkg::*;
#(
    parameter int        DEPTH = EDGE_DEPTH,
    parameter edge_rec_t [DEPTH-1:0] TABLE = NORM_TABLE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output edge_rec_t         rec_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q <= '0;
        end else if (rd_en) begin
            if (int'(rd_addr) < DEPTH) rec_q <= TABLE[rd_addr];
            else                       rec_q <= '0;
        end
    end
endmodule

// File: rtl/evdd_addr_gen.sv
module evdd_addr_gen
    import evdd_pkg::*;
#(
    parameter int W_IN  = IN_W,
    parameter int W_WIN = WIN_W
) (
    input  logic [W_IN-1:0]    word_in,
    input  logic [SHIFT_W-1:0] shift,
    input  logic [W_WIN-1:0]   mask,
    input  logic [ADDR_W-1:0]  node,
    output logic [W_IN-1:0]    word_out,
    output logic [ADDR_W-1:0]  edge_addr
);
    logic [W_WIN-1:0] window;

    always_comb begin
        word_out  = word_in << shift;
        window    = word_out[W_IN-1 -: W_WIN];
        edge_addr = node + ADDR_W'(window & mask);
    end
endmodule

// File: rtl/evdd_weight_acc.sv
module evdd_weight_acc
    import evdd_pkg::*;
#(
    parameter int W_SUM = SUM_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clear,
    input  logic                       add_en,
    input  logic signed [WEIGHT_W-1:0] weight,
    output logic signed [W_SUM-1:0]    sum_q,
    output logic signed [W_SUM-1:0]    sum_next
);
    localparam int EXT_W = W_SUM - WEIGHT_W;

    always_comb sum_next = sum_q + {{EXT_W{weight[WEIGHT_W-1]}}, weight};

    always_ff @(posedge clk) begin
        if (rst || clear) sum_q <= '0;
        else if (add_en)  sum_q <= sum_next;
    end
endmodule

// File: rtl/evdd_eval.sv
module evdd_eval
    import evdd_pkg::*;
#(
    parameter int        DEPTH  = EDGE_DEPTH,
    parameter int        RES_W  = SUM_W,
    parameter edge_rec_t [DEPTH-1:0] EDGE_TABLE = NORM_TABLE
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [OP_W-1:0]         op_x,
    input  logic [OP_W-1:0]         op_y,
    output logic                    done,
    output logic signed [RES_W-1:0] result
);
    walk_state_e       state;
    edge_rec_t         rec;
    logic [IN_W-1:0]   word_q, ag_word_in, ag_word_out;
    logic [SHIFT_W-1:0] ag_shift;
    logic [WIN_W-1:0]  ag_mask;
    logic [ADDR_W-1:0] ag_node, ag_addr;
    logic              busy, accept, at_term, rd_en;
    logic signed [RES_W-1:0] sum_q, sum_next;

    always_comb begin
        busy       = (state == ST_WALK);
        accept     = !busy && start;
        at_term    = busy && (rec.mask == '0);
        rd_en      = accept || (busy && !at_term);
        ag_word_in = busy ? word_q   : {op_x, op_y};
        ag_shift   = busy ? rec.shift : '0;
        ag_mask    = busy ? rec.mask  : '1;
        ag_node    = busy ? rec.node  : '0;
    end

    evdd_addr_gen #(.W_IN(IN_W), .W_WIN(WIN_W)) u_addr (
        .word_in  (ag_word_in),
        .shift    (ag_shift),
        .mask     (ag_mask),
        .node     (ag_node),
        .word_out (ag_word_out),
        .edge_addr(ag_addr)
    );

    evdd_edge_rom #(.DEPTH(DEPTH), .TABLE(EDGE_TABLE)) u_rom (
        .clk    (clk),
        .rst    (rst),
        .rd_en  (rd_en),
        .rd_addr(ag_addr),
        .rec_q  (rec)
    );

    evdd_weight_acc #(.W_SUM(RES_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .add_en  (busy && !at_term),
        .weight  (rec.weight),
        .sum_q   (sum_q),
        .sum_next(sum_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            word_q <= '0;
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= at_term;
            if (accept) begin
                state  <= ST_WALK;
                word_q <= ag_word_out;
            end else if (busy) begin
                if (at_term) begin
                    state  <= ST_IDLE;
                    result <= sum_next;
                end else begin
                    word_q <= ag_word_out;
                end
            end
        end
    end
endmodule

// File: rtl/evdd_eval_chk.sv
module evdd_eval_chk #(
    parameter int RES_W = 6
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    start,
    input logic                    done,
    input logic                    busy,
    input logic                    at_term,
    input logic signed [RES_W-1:0] sum_q,
    input logic signed [RES_W-1:0] result
);
    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));

    a_r4_term_done: assert property (@(posedge clk) disable iff (rst)
        at_term |=> done);

    a_r7_walk_continues: assert property (@(posedge clk) disable iff (rst)
        (busy && !at_term) |=> busy);

    a_r3_sum_cleared: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && sum_q == '0));

    a_r5_done_after_walk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));
endmodule

bind evdd_eval evdd_eval_chk #(.RES_W(RES_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .done   (done),
    .busy   (busy),
    .at_term(at_term),
    .sum_q  (sum_q),
    .result (result)
);

// File: tb/evdd_eval_test.sv
module evdd_eval_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [1:0] op_x = '0, op_y = '0;
    logic done;
    logic signed [5:0] result;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    evdd_eval uut (
        .clk(clk), .rst(rst), .start(start),
        .op_x(op_x), .op_y(op_y), .done(done), .result(result)
    );

    function automatic int ref_norm(int x, int y);
        int s = x * x + y * y;
        int r = 0;
        while ((2 * r + 1) * (2 * r + 1) <= 4 * s) r++;
        return r;
    endfunction

    // A second node is visited only when y0 changes the value.
    function automatic int ref_len(int x, int y);
        int yh = (y / 2) * 2;
        return (ref_norm(x, yh) != ref_norm(x, yh + 1)) ? 2 : 1;
    endfunction

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run(int x, int y, output int res, output int lat);
        int cyc;
        @(negedge clk);
        op_x = 2'(x); op_y = 2'(y); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 20) begin
            @(negedge clk);
            cyc++;
        end
        res = int'(result);
        lat = cyc - 1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int res, lat, held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 done after reset", int'(done), 0);
        chk("R9 result after reset", int'(result), 0);

        // Worked example: two edges, value 3
        run(2, 2, res, lat);
        chk("R2 R10 example result", res, 3);
        chk("R5 example latency", lat, 2);

        // Exhaustive sweep
        for (int x = 0; x < 4; x++) begin
            for (int y = 0; y < 4; y++) begin
                run(x, y, res, lat);
                chk($sformatf("R10 R3 R4 norm x=%0d y=%0d", x, y), res, ref_norm(x, y));
                chk($sformatf("R1 R5 latency x=%0d y=%0d", x, y), lat, ref_len(x, y));
                held = res;
                @(negedge clk);
                chk("R6 done single pulse", int'(done), 0);
                chk("R8 result held", int'(result), held);
                @(negedge clk);
                chk("R8 result held later", int'(result), held);
            end
        end

        // R7: start held with new operands during a walk
        @(negedge clk);
        op_x = 2'd2; op_y = 2'd2; start = 1'b1;
        @(negedge clk);
        op_x = 2'd0; op_y = 2'd3;
        @(negedge clk);
        start = 1'b0;
        chk("R7 no done mid-walk", int'(done), 0);
        @(negedge clk);
        chk("R7 done on schedule", int'(done), 1);
        chk("R7 result of first operands", int'(result), 3);
        repeat (4) begin
            @(negedge clk);
            chk("R7 no restarted walk", int'(done), 0);
            chk("R7 R8 result unchanged", int'(result), 3);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule